// File: doc/BRIEF.md
# Two-Space Serial Slave with Independent Address Pointers

This block is a two-wire serial bus slave (I2C-style framing) that answers two device IDs. One ID opens a byte-wide memory array that is addressed with two address bytes. The other opens a small bank of special-function registers that is addressed with one address byte. Both the array and the bank sit outside the block. The block drives their address, write-data and write-strobe signals, and it reads back their combinational read data.

Each space owns its own address pointer. A master can stop part-way through a memory read, touch a few registers, and then issue a current-address memory read that carries on from the byte after the last one it read. Each transaction can be one of five kinds:
- a single-byte write
- a burst write
- a current-address read
- a selective read, made of a write header, address bytes, a repeated start and a read header
- a sequential read

SCL and SDA are open-drain lines. The block takes each one as an input level. It controls SDA only through an output enable that pulls the line low. Both bus inputs pass through a synchronizer clocked by the system clock, so SCL must stay low and high for several system clocks.

Top module: `dual_ptr_i2c_slave`

## Requirements
- R1: The first byte after a start is a slave address. Bits 7..1 hold the device ID and bit 0 holds the direction (1 = read, 0 = write). When the ID equals MEM_ID or REG_ID, the slave acknowledges by holding SDA low during the ninth SCL pulse.
- R2: For any other ID, the slave never enables its SDA driver until the next start or stop.
- R3: A memory write header is followed by a high address byte and then a low address byte. The pointer loads from the lower MEM_AW bits of {high, low}. Each following data byte is acknowledged and written at the pointer, and the pointer then increments, wrapping from 2^MEM_AW-1 to 0. A write header followed directly by a stop loads nothing and writes nothing.
- R4: A register write header is followed by one address byte, whose lower REG_AW bits load the register pointer. Each following data byte is acknowledged and written, and the pointer then increments, wrapping within 2^REG_AW.
- R5: After a matched read header is acknowledged, the byte at the selected pointer is driven MSB first. Its first bit appears in the SCL low phase that follows the acknowledge pulse.
- R6: Every byte the slave sends advances the selected pointer by one, including a byte the master answers with NACK. A master ACK makes the slave send the next byte. A NACK makes the slave release SDA until the next start.
- R7: A selective read works as follows. The address bytes are written, a repeated start abandons the write without storing any data, and the read header that follows reads from the freshly loaded address.
- R8: Accesses to one space leave the other space's pointer unchanged. A memory read therefore resumes from where the previous memory read stopped.
- R9: A start or stop at any point aborts the byte in progress. A stop returns the slave to idle with SDA released. A start awaits a new slave address.
- R10: The SDA enable changes only while SCL is low, except in response to a start or stop.
- R11: Each written byte produces exactly one single-cycle write strobe. The memory and register strobes never fire together, and read transactions produce no strobe.
- R12: After reset, the SDA enable and both write strobes are low, and both pointers are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When high, pulls SDA low |
| mem_addr | output | MEM_AW | Memory pointer, used for reads and writes |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe, one cycle |
| mem_rdata | input | 8 | Combinational memory read data at mem_addr |
| reg_addr | output | REG_AW | Register pointer, used for reads and writes |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Register write strobe, one cycle |
| reg_rdata | input | 8 | Combinational register read data at reg_addr |

## Verification
The bench builds the block with MEM_AW = 6 and REG_AW = 3, so the memory space has 64 bytes and the register bank has 8. With these sizes, a four-byte burst that starts near the top of either space crosses the wrap point. A high address byte with non-zero upper bits shows that address bits above the space width are dropped. The small spaces also let the bench compare its entire behavioural image of both spaces against the bench-side arrays after the run.

// File: rtl/i2c_dp_pkg.sv
// Shared types for the two-space serial slave.
package i2c_dp_pkg;

    // Transaction phase tracked by the protocol engine.
    typedef enum logic [2:0] {
        ST_IDLE,   // bus released, waiting for a start
        ST_DEV,    // receiving the slave address byte
        ST_AHI,    // receiving the high memory address byte
        ST_ALO,    // receiving the low (or only) address byte
        ST_WDAT,   // receiving write data
        ST_RDAT,   // sending read data
        ST_SKIP    // not addressed or read finished: silent until start/stop
    } dp_state_t;

    // Which address space the current transaction targets.
    typedef enum logic {
        SP_MEM,
        SP_REG
    } dp_space_t;

endpackage

// File: rtl/i2c_dp_line.sv
// Line conditioner: synchronizes SCL/SDA to clk and flags edges and bus
// conditions as single-cycle pulses.
// Assumes each SCL level lasts several clk periods and SDA is stable
// around SCL edges, except when the master signals a start or stop.
module i2c_dp_line #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_hi,
    output logic sda_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_q;
    logic                   sda_q;

    // Synchronizer chains plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_sync[SYNC_STAGES-1];
            sda_q    <= sda_sync[SYNC_STAGES-1];
        end
    end

    // Event decode from current and previous synchronized levels.
    always_comb begin
        scl_hi    = scl_sync[SYNC_STAGES-1];
        sda_hi    = sda_sync[SYNC_STAGES-1];
        scl_rise  = scl_hi & ~scl_q;
        scl_fall  = ~scl_hi & scl_q;
        bus_start = scl_hi & scl_q & sda_q & ~sda_hi;
        bus_stop  = scl_hi & scl_q & ~sda_q & sda_hi;
    end

endmodule

// File: rtl/i2c_dp_ptr.sv
// Wrapping address pointer for one address space.
// A load takes priority over an increment; the increment wraps at 2^AW.
module i2c_dp_ptr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);

    // Pointer register: reset to zero, load, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (ld)  ptr <= ld_val;
        else if (inc) ptr <= ptr + AW'(1);
    end

endmodule

// File: rtl/dual_ptr_i2c_slave.sv
// Two-space serial slave. MEM_ID selects an external byte array (two address
// bytes); REG_ID selects an external register bank (one address byte).
// Each space keeps its own pointer. Read data from both spaces is expected
// combinationally at the pointer address. Assumes MEM_AW <= 16, REG_AW <= 8.
module dual_ptr_i2c_slave
    import i2c_dp_pkg::*;
#(
    parameter int         MEM_AW      = 16,
    parameter int         REG_AW      = 4,
    parameter logic [6:0] MEM_ID      = 7'h50,
    parameter logic [6:0] REG_ID      = 7'h68,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic [7:0]        mem_rdata,
    output logic [REG_AW-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    output logic              reg_we,
    input  logic [7:0]        reg_rdata
);

    localparam int         BITS_W   = 4;
    localparam logic [3:0] LAST_BIT = 4'd7;
    localparam logic [3:0] ACK_BIT  = 4'd8;

    logic scl_hi, sda_hi, scl_rise, scl_fall, bus_start, bus_stop;

    dp_state_t         st;
    dp_space_t         sp;
    logic [BITS_W-1:0] bit_cnt;
    logic [6:0]        rx_sr;
    logic [7:0]        rx_byte;
    logic [7:0]        hi_byte;
    logic [7:0]        tx_byte;
    logic [7:0]        tx_shift;
    logic [7:0]        rd_byte;
    logic [7:0]        wdata_q;
    logic [15:0]       ld_val_q;
    logic              ack_pend, in_tx, tx_go;
    logic              wr_stb, rd_inc, ld_q;
    logic              byte_done, ack_clk;

    i2c_dp_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_hi   (scl_hi),
        .sda_hi   (sda_hi),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    i2c_dp_ptr #(.AW(MEM_AW)) u_mem_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld_q && sp == SP_MEM),
        .ld_val(ld_val_q[MEM_AW-1:0]),
        .inc   ((wr_stb || rd_inc) && sp == SP_MEM),
        .ptr   (mem_addr)
    );

    i2c_dp_ptr #(.AW(REG_AW)) u_reg_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld_q && sp == SP_REG),
        .ld_val(ld_val_q[REG_AW-1:0]),
        .inc   ((wr_stb || rd_inc) && sp == SP_REG),
        .ptr   (reg_addr)
    );

    // Byte assembly, bit-slot decode, read mux and strobe fan-out.
    always_comb begin
        rx_byte   = {rx_sr, sda_hi};
        byte_done = scl_rise && (bit_cnt == LAST_BIT);
        ack_clk   = scl_rise && (bit_cnt == ACK_BIT);
        rd_byte   = (sp == SP_MEM) ? mem_rdata : reg_rdata;
        tx_shift  = tx_byte << bit_cnt[2:0];
        mem_we    = wr_stb && (sp == SP_MEM);
        reg_we    = wr_stb && (sp == SP_REG);
        mem_wdata = wdata_q;
        reg_wdata = wdata_q;
    end

    // Protocol engine: framing, address decode, ACK and data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            sp       <= SP_MEM;
            bit_cnt  <= '0;
            rx_sr    <= '0;
            hi_byte  <= '0;
            tx_byte  <= '0;
            wdata_q  <= '0;
            ld_val_q <= '0;
            ack_pend <= 1'b0;
            in_tx    <= 1'b0;
            tx_go    <= 1'b0;
            wr_stb   <= 1'b0;
            rd_inc   <= 1'b0;
            ld_q     <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_inc <= 1'b0;
            ld_q   <= 1'b0;
            if (bus_stop || bus_start) begin
                st       <= bus_start ? ST_DEV : ST_IDLE;
                bit_cnt  <= '0;
                ack_pend <= 1'b0;
                in_tx    <= 1'b0;
                tx_go    <= 1'b0;
                sda_oe   <= 1'b0;
            end else begin
                if (scl_rise && st != ST_IDLE) begin
                    bit_cnt <= (bit_cnt == ACK_BIT) ? '0 : bit_cnt + 1'b1;
                    if (bit_cnt < LAST_BIT) rx_sr <= {rx_sr[5:0], sda_hi};
                end
                if (byte_done) begin
                    case (st)
                        ST_DEV: begin
                            if (rx_byte[7:1] == MEM_ID || rx_byte[7:1] == REG_ID) begin
                                sp       <= (rx_byte[7:1] == MEM_ID) ? SP_MEM : SP_REG;
                                ack_pend <= 1'b1;
                                if (rx_byte[0])                  st <= ST_RDAT;
                                else if (rx_byte[7:1] == MEM_ID) st <= ST_AHI;
                                else                             st <= ST_ALO;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                        ST_AHI: begin
                            hi_byte  <= rx_byte;
                            ack_pend <= 1'b1;
                            st       <= ST_ALO;
                        end
                        ST_ALO: begin
                            ld_val_q <= (sp == SP_MEM) ? {hi_byte, rx_byte} : {8'h00, rx_byte};
                            ld_q     <= 1'b1;
                            ack_pend <= 1'b1;
                            st       <= ST_WDAT;
                        end
                        ST_WDAT: begin
                            wdata_q  <= rx_byte;
                            wr_stb   <= 1'b1;
                            ack_pend <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                if (ack_clk && st == ST_RDAT) begin
                    if (!in_tx) begin
                        tx_go <= 1'b1;
                    end else begin
                        rd_inc <= 1'b1;
                        if (!sda_hi) begin
                            tx_go <= 1'b1;
                        end else begin
                            st    <= ST_SKIP;
                            in_tx <= 1'b0;
                        end
                    end
                end
                if (scl_fall) begin
                    if (bit_cnt == ACK_BIT) begin
                        sda_oe <= ack_pend;
                    end else if (bit_cnt == '0) begin
                        ack_pend <= 1'b0;
                        if (tx_go) begin
                            tx_byte <= rd_byte;
                            sda_oe  <= ~rd_byte[7];
                            in_tx   <= 1'b1;
                            tx_go   <= 1'b0;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end else if (in_tx && st == ST_RDAT) begin
                        sda_oe <= ~tx_shift[7];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/i2c_dp_checks.sv
// Property checker for the two-space serial slave; attached by bind.
// Observes the line levels, engine phase, pointers and strobes.
module i2c_dp_checks
    import i2c_dp_pkg::*;
#(
    parameter int MEM_AW = 16,
    parameter int REG_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_hi,
    input logic              bus_start,
    input logic              bus_stop,
    input logic              sda_oe,
    input logic              mem_we,
    input logic              reg_we,
    input dp_state_t         st,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [REG_AW-1:0] reg_addr
);

    // R10: driver moves only in the SCL low phase or on a bus condition.
    a_r10_sda_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_hi) || $past(bus_start) || $past(bus_stop)));

    // R11: strobes are exclusive and single-cycle.
    a_r11_one_space: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && reg_we));
    a_r11_mem_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
    a_r11_reg_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R3: each memory write steps the memory pointer by one with wrap.
    a_r3_mem_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> mem_addr == MEM_AW'($past(mem_addr) + 1'b1));

    // R4: each register write steps the register pointer by one with wrap.
    a_r4_reg_step: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> reg_addr == REG_AW'($past(reg_addr) + 1'b1));

    // R8: register writes leave the memory pointer alone, and vice versa.
    a_r8_mem_kept: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> $stable(mem_addr));
    a_r8_reg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> $stable(reg_addr));

    // R2: an unaddressed or finished slave keeps SDA released.
    a_r2_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> !sda_oe);

    // R9: idle after a stop means SDA released and no writes.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!sda_oe && !mem_we && !reg_we));

endmodule

bind dual_ptr_i2c_slave i2c_dp_checks #(
    .MEM_AW(MEM_AW),
    .REG_AW(REG_AW)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_hi   (scl_hi),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .sda_oe   (sda_oe),
    .mem_we   (mem_we),
    .reg_we   (reg_we),
    .st       (st),
    .mem_addr (mem_addr),
    .reg_addr (reg_addr)
);

// File: tb/dual_ptr_i2c_slave_bench.sv
// Bench: behavioural master, bench-side memory/register arrays and an
// integer reference model of both spaces and pointers.
module dual_ptr_i2c_slave_bench;

    localparam int         MAW = 6;
    localparam int         RAW = 3;
    localparam int         MSZ = 1 << MAW;
    localparam int         RSZ = 1 << RAW;
    localparam logic [6:0] MID = 7'h50;
    localparam logic [6:0] RID = 7'h68;
    localparam int         Q   = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           scl = 1'b1;
    logic           sda_m = 1'b1;
    logic           sda_ln;
    logic           sda_oe;
    logic [MAW-1:0] mem_addr;
    logic [7:0]     mem_wdata, mem_rdata, reg_wdata, reg_rdata;
    logic           mem_we, reg_we;
    logic [RAW-1:0] reg_addr;

    logic [7:0] mem_arr [MSZ];
    logic [7:0] reg_arr [RSZ];
    int mdl_mem [MSZ];
    int mdl_reg [RSZ];
    int mptr = 0;
    int rptr = 0;

    int n_vec = 0;
    int n_bad = 0;
    int n_mwe = 0;
    int n_rwe = 0;
    bit quiet = 0;
    bit no_wr = 0;
    bit done  = 0;
    logic scl_prev = 1'b1;
    logic oe_prev  = 1'b0;

    always #10 clk = ~clk;

    assign sda_ln    = sda_m & ~sda_oe;
    assign mem_rdata = mem_arr[mem_addr];
    assign reg_rdata = reg_arr[reg_addr];

    dual_ptr_i2c_slave #(
        .MEM_AW(MAW), .REG_AW(RAW), .MEM_ID(MID), .REG_ID(RID)
    ) u_dual_ptr_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_ln), .sda_oe(sda_oe),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    // Bench-side storage written through the block's strobes.
    always @(posedge clk) begin
        if (mem_we) mem_arr[mem_addr] <= mem_wdata;
        if (reg_we) reg_arr[reg_addr] <= reg_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model's rules for SDA and strobes.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(!(mem_we && reg_we), "R11 exclusive strobes", {mem_we, reg_we}, 0);
            if (no_wr) chk(!mem_we && !reg_we, "R11 no strobe in read/aborted", {mem_we, reg_we}, 0);
            if (quiet) chk(!sda_oe, "R2/R9 slave silent", sda_oe, 0);
            if (scl && scl_prev) chk(sda_oe == oe_prev, "R10 SDA stable while SCL high", sda_oe, oe_prev);
            if (mem_we) n_mwe++;
            if (reg_we) n_rwe++;
        end
        scl_prev = scl;
        oe_prev  = sda_oe;
    end

    task automatic tk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tk(Q); scl = 1'b1; tk(Q);
        sda_m = 1'b0; tk(Q); scl = 1'b0; tk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tk(Q); scl = 1'b1; tk(Q);
        sda_m = 1'b1; tk(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tk(Q); scl = 1'b1; tk(Q); scl = 1'b0; tk(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1'b1; tk(Q); scl = 1'b1; tk(Q);
        acked = !sda_ln;
        scl = 1'b0; tk(Q);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tk(Q); scl = 1'b1; tk(Q); b[i] = sda_ln; scl = 1'b0;
        end
        tk(Q); sda_m = ack ? 1'b0 : 1'b1; tk(Q);
        scl = 1'b1; tk(Q); scl = 1'b0; tk(Q); sda_m = 1'b1;
    endtask

    task automatic hdr(input logic [6:0] id, input bit rd, input string req);
        bit a;
        send_byte({id, rd}, a);
        chk(a, req, a, 1);
    endtask

    task automatic read_n(input bit is_mem, input int n, input string req);
        logic [7:0] b;
        no_wr = 1;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            if (is_mem) begin
                chk(b == mdl_mem[mptr], req, b, mdl_mem[mptr]);
                mptr = (mptr + 1) % MSZ;
            end else begin
                chk(b == mdl_reg[rptr], req, b, mdl_reg[rptr]);
                rptr = (rptr + 1) % RSZ;
            end
        end
        bus_stop();
        no_wr = 0;
    endtask

    task automatic mem_seek(input logic [7:0] hi, input logic [7:0] lo);
        bit a;
        bus_start(); hdr(MID, 0, "R1 mem write header ACK");
        send_byte(hi, a); chk(a, "R3 high address ACK", a, 1);
        send_byte(lo, a); chk(a, "R3 low address ACK", a, 1);
        mptr = int'({hi, lo}) % MSZ;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        tk(200000);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        bit a;
        logic [7:0] dat [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
        int mw0, rw0;
        for (int i = 0; i < MSZ; i++) begin mem_arr[i] = 8'((i * 37 + 5) & 255); mdl_mem[i] = (i * 37 + 5) & 255; end
        for (int i = 0; i < RSZ; i++) begin reg_arr[i] = 8'(i * 17 + 1); mdl_reg[i] = (i * 17 + 1) & 255; end
        tk(5); rst_n = 1'b1; tk(2);

        // R12: reset state at the ports.
        chk(!sda_oe && !mem_we && !reg_we, "R12 reset outputs", {sda_oe, mem_we, reg_we}, 0);
        chk(mem_addr == 0 && reg_addr == 0, "R12 reset pointers", {mem_addr, reg_addr}, 0);

        // R3: burst memory write across the wrap; high byte bits above MEM_AW dropped.
        mw0 = n_mwe;
        mem_seek(8'h12, 8'h3E);
        for (int k = 0; k < 4; k++) begin
            send_byte(dat[k], a); chk(a, "R3 data ACK", a, 1);
            mdl_mem[mptr] = dat[k]; mptr = (mptr + 1) % MSZ;
        end
        bus_stop();
        chk(n_mwe - mw0 == 4, "R11 one strobe per memory byte", n_mwe - mw0, 4);
        chk(mem_addr == MAW'(mptr), "R3 pointer wrapped", mem_addr, mptr);

        // R4: register write with wrap inside the bank; upper address bits dropped.
        rw0 = n_rwe;
        bus_start(); hdr(RID, 0, "R1 reg write header ACK");
        send_byte(8'hF6, a); chk(a, "R4 reg address ACK", a, 1);
        rptr = 6;
        for (int k = 0; k < 3; k++) begin
            send_byte(8'(8'h11 * (k + 1)), a); chk(a, "R4 reg data ACK", a, 1);
            mdl_reg[rptr] = 8'h11 * (k + 1); rptr = (rptr + 1) % RSZ;
        end
        bus_stop();
        chk(n_rwe - rw0 == 3, "R11 one strobe per register byte", n_rwe - rw0, 3);
        chk(mem_addr == MAW'(mptr), "R8 memory pointer kept by reg write", mem_addr, mptr);

        // R5/R6: current-address memory read, two bytes, ACK then NACK.
        bus_start(); hdr(MID, 1, "R1 mem read header ACK");
        read_n(1, 2, "R5/R6 current-address sequential read");
        chk(mem_addr == MAW'(mptr), "R6 pointer advanced after NACK", mem_addr, mptr);

        // R7: selective register read through repeated start, wrapping.
        rw0 = n_rwe;
        bus_start(); hdr(RID, 0, "R7 reg write header ACK");
        send_byte(8'h07, a); chk(a, "R7 reg address ACK", a, 1);
        rptr = 7;
        bus_start(); hdr(RID, 1, "R7 reg read header ACK");
        read_n(0, 2, "R7/R4 selective reg read");
        chk(n_rwe == rw0, "R7 repeated start wrote nothing", n_rwe - rw0, 0);

        // R8: memory read resumes after register traffic.
        bus_start(); hdr(MID, 1, "R8 mem read header ACK");
        read_n(1, 1, "R8 memory read resumes");

        // R7/R3: selective memory read across the top of the space.
        mem_seek(8'h00, 8'h3F);
        bus_start(); hdr(MID, 1, "R7 mem read header ACK");
        read_n(1, 2, "R7/R3 selective mem read wrap");

        // R2: foreign ID gets no ACK and no SDA activity.
        bus_start(); quiet = 1; no_wr = 1;
        send_byte({7'h2A, 1'b0}, a); chk(!a, "R2 foreign ID not acknowledged", a, 0);
        send_byte(8'h00, a);         chk(!a, "R2 following byte ignored", a, 0);
        bus_stop(); quiet = 0; no_wr = 0;

        // R9: start then stop in mid-byte aborts cleanly.
        bus_start(); quiet = 1; no_wr = 1;
        send_bits({MID, 1'b0}, 4);
        bus_stop(); quiet = 0; no_wr = 0;
        bus_start(); hdr(MID, 1, "R9 header after abort ACK");
        read_n(1, 1, "R9 pointer intact after abort");

        // R3: write header without address changes nothing.
        mw0 = n_mwe;
        bus_start(); hdr(MID, 0, "R3 bare write header ACK");
        bus_stop();
        chk(n_mwe == mw0, "R3 bare header wrote nothing", n_mwe - mw0, 0);
        bus_start(); hdr(MID, 1, "R3 read after bare header ACK");
        read_n(1, 1, "R3 pointer unchanged by bare header");

        // R3/R4: full image comparison of both spaces.
        for (int i = 0; i < MSZ; i++) chk(mem_arr[i] == mdl_mem[i], "R3 memory image", mem_arr[i], mdl_mem[i]);
        for (int i = 0; i < RSZ; i++) chk(reg_arr[i] == mdl_reg[i], "R4 register image", reg_arr[i], mdl_reg[i]);

        tk(5);
        finish_run();
    end

endmodule